// File: doc/BRIEF.md
# Flash Command Engine with Signature Area

This block is the command front end of an embedded flash model. Software drives it through a small register interface: a mode register, a command register, and a status register. Every command word must carry a protection keyword, and a command is carried out only when that keyword is correct. The engine works on a separate 512-byte signature area, held as 128 words of 32 bits. It offers four operations on that area: enter a read mode, leave the read mode, program one page from a page latch, and erase the whole area.

Software fills the page latch by writing words anywhere in the flash window. The low six bits of the word address pick the latch slot. A program command copies the latch into one half of the signature area. While the read mode is active, the first 128 words of the flash read window return signature contents rather than main-array contents.

A behavioural array model stands in for the flash cells. It can be told, through a defect input, that bit 0 of every cell it writes sticks at 0. A verify pass at the end of each program or erase then reports the mismatch as a flash error.

Top module: `nvm_sig_ctrl`

## Requirements
- R1: After reset, status reads 0x1 (ready set, both error flags clear), the mode register reads 0, `irq` is low, and every signature word holds 0xFFFFFFFF.
- R1: After reset, the flash window outside the read mode returns the main-array pattern 0xC0DE0000 OR word address.
- R2: A command word has the keyword in bits 31:24, an argument in bits 23:8 and an opcode in bits 7:0. A keyword other than 0x5A sets the command-error flag (status bit 1), and the command is not executed.
- R3: Opcode 0x21 in the idle state enters the read mode, and ready (status bit 0) reads 0 from the next cycle. Flash reads at word addresses 0..127 then return signature words, and reads at higher addresses still return the main pattern.
- R4: Opcode 0x22 in the read mode leaves it. Ready returns to 1, and word addresses 0..127 return the main pattern again.
- R5: A flash-window write stores its data in latch slot `addr[5:0]`. Opcode 0x23 copies the 64 latch words into signature page `arg` (words arg*64..arg*64+63) and leaves the other page unchanged. Ready is low for exactly PROG_CYCLES cycles after the command edge.
- R6: Opcode 0x24 sets all 128 signature words to 0xFFFFFFFF, with the same ready-low window as a program.
- R7: A command written while a program or erase is in progress is not executed and sets the command-error flag.
- R8: At the end of a program or erase, the flash-error flag (status bit 2) is set if the signature contents differ from the intended data. With `array_defect` high at the command edge, bit 0 of every cell written is stored as 0.
- R9: Reading the status register (address 2) clears both error flags and `irq`, but does not change ready.
- R10: When ready rises at the end of a stop, program or erase with the interrupt enable (mode register bit 0, address 0) set, `irq` goes high and stays high until a status read. With the enable clear, `irq` stays low.
- R11: A correctly keyed command is a command error and is not executed when its opcode is unknown, when it does not fit the state (a start or an erase in the read mode, a stop outside the read mode), or when a program's arg is 2 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a status read clears flags) |
| reg_addr | input | 2 | Register select: 0 mode, 1 command, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fl_wr | input | 1 | Flash-window write, loads the page latch |
| fl_addr | input | AW | Flash-window word address |
| fl_wdata | input | 32 | Flash-window write data |
| fl_rdata | output | 32 | Flash-window read data (combinational) |
| array_defect | input | 1 | Model fault: bit 0 of written cells sticks at 0 |
| irq | output | 1 | Ready interrupt, level until status read |

## Verification
The bench builds the block with PROG_CYCLES set to 6, and keeps the default 1024-word window and the 128-word signature area with 64-word pages. The short busy window lets the bench poll the status register and count exactly how many cycles ready stays low. It also lets the bench place a second command inside that window. With two signature pages, a program into the upper page can be told apart from the untouched lower page. Reads at addresses just above 127 show where the signature overlay ends.

// File: rtl/nvm_sig_pkg.sv
// Package: shared constants and the state type of the signature command engine.
// Assumes a 32-bit register interface with keyword/argument/opcode packing.
package nvm_sig_pkg;
    localparam logic [7:0] CMD_KEY      = 8'h5A;
    localparam logic [7:0] OP_RD_START  = 8'h21;
    localparam logic [7:0] OP_RD_STOP   = 8'h22;
    localparam logic [7:0] OP_SIG_PROG  = 8'h23;
    localparam logic [7:0] OP_SIG_ERASE = 8'h24;

    localparam logic [1:0] REG_MODE = 2'd0;
    localparam logic [1:0] REG_CMD  = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RDMODE = 2'd1,
        ST_BUSY   = 2'd2
    } eng_state_e;
endpackage

// File: rtl/nvm_page_latch.sv
// Page latch: holds one page of words that software writes through the flash
// window. Only the low address bits pick the slot, so any page address works.
// Assumes WORDS is a power of two.
module nvm_page_latch #(
    parameter int WORDS = 64,
    parameter int DW    = 32,
    localparam int LW   = $clog2(WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [LW-1:0]         wr_slot,
    input  logic [DW-1:0]         wr_data,
    output logic [WORDS*DW-1:0]   page_flat
);
    logic [DW-1:0] slot_q [WORDS];

    // Capture a written word into its slot; clear all slots on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) slot_q[i] <= '0;
        end else if (wr_en) begin
            slot_q[wr_slot] <= wr_data;
        end
    end

    // Present the latch as one flat vector for the array model.
    for (genvar g = 0; g < WORDS; g++) begin : g_flat
        assign page_flat[g*DW +: DW] = slot_q[g];
    end
endmodule

// File: rtl/nvm_sig_array.sv
// Signature array model: SIG_WORDS cells written a page at a time or erased
// all at once. A defect input makes bit 0 of every cell written stick at 0.
// A verify output compares the cells against the intended data of the last
// operation. Assumes SIG_WORDS is a power-of-two multiple (>= 2) of PAGE_WORDS.
module nvm_sig_array #(
    parameter int SIG_WORDS  = 128,
    parameter int PAGE_WORDS = 64,
    parameter int DW         = 32,
    localparam int SAW       = $clog2(SIG_WORDS),
    localparam int LW        = $clog2(PAGE_WORDS),
    localparam int PG_W      = SAW - LW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       prog_en,
    input  logic                       erase_en,
    input  logic [PG_W-1:0]            page_sel,
    input  logic                       defect,
    input  logic [PAGE_WORDS*DW-1:0]   latch_flat,
    input  logic [SAW-1:0]             rd_idx,
    output logic [DW-1:0]              rd_word,
    output logic                       vfy_fail
);
    logic [DW-1:0]   cell_q [SIG_WORDS];
    logic            last_erase_q;
    logic [PG_W-1:0] last_page_q;
    logic [DW-1:0]   wr_mask;

    // Mask applied to every cell write: the defect forces bit 0 low.
    assign wr_mask = defect ? {{(DW-1){1'b1}}, 1'b0} : '1;

    // Commit an erase or a page program into the cells; remember the operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SIG_WORDS; i++) cell_q[i] <= '1;
            last_erase_q <= 1'b1;
            last_page_q  <= '0;
        end else if (erase_en) begin
            for (int i = 0; i < SIG_WORDS; i++) cell_q[i] <= wr_mask;
            last_erase_q <= 1'b1;
        end else if (prog_en) begin
            for (int i = 0; i < PAGE_WORDS; i++)
                cell_q[{page_sel, LW'(i)}] <= latch_flat[i*DW +: DW] & wr_mask;
            last_erase_q <= 1'b0;
            last_page_q  <= page_sel;
        end
    end

    // Verify pass: compare the cells touched last against their intended data.
    always_comb begin
        vfy_fail = 1'b0;
        for (int i = 0; i < SIG_WORDS; i++) begin
            if (last_erase_q) begin
                if (cell_q[i] != '1) vfy_fail = 1'b1;
            end else if (PG_W'(i / PAGE_WORDS) == last_page_q) begin
                if (cell_q[i] != latch_flat[(i % PAGE_WORDS)*DW +: DW]) vfy_fail = 1'b1;
            end
        end
    end

    // Read port for the signature overlay.
    assign rd_word = cell_q[rd_idx];

    // R6: a clean erase leaves the first and last cell all ones.
    p_erase_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_en && !defect) |=> (cell_q[0] == '1 && cell_q[SIG_WORDS-1] == '1));

    // R8: a defective write always leaves bit 0 of the first touched cell low.
    p_defect_bit0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_en && defect) |=> (cell_q[0][0] == 1'b0));
endmodule

// File: rtl/nvm_cmd_engine.sv
// Command engine: checks the keyword, decodes the opcode against the state,
// runs the busy window of a program or erase, and keeps the ready flag,
// error flags and the interrupt. Assumes PROG_CYCLES >= 1.
module nvm_cmd_engine
    import nvm_sig_pkg::*;
#(
    parameter int PROG_CYCLES = 16,
    parameter int NPAGES      = 2,
    localparam int PG_W       = $clog2(NPAGES),
    localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_we,
    input  logic [7:0]      cmd_key,
    input  logic [15:0]     cmd_arg,
    input  logic [7:0]      cmd_op,
    input  logic            ien,
    input  logic            stat_rd,
    input  logic            vfy_fail,
    output logic            ready,
    output logic            rd_mode,
    output logic            err_cmd,
    output logic            err_flash,
    output logic            irq,
    output logic            do_prog,
    output logic            do_erase,
    output logic [PG_W-1:0] page_sel
);
    eng_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             key_ok, acc_start, acc_stop, cmd_bad;

    // Decode which command, if any, is accepted this cycle.
    always_comb begin
        key_ok    = cmd_we && (cmd_key == CMD_KEY);
        acc_start = key_ok && state_q == ST_IDLE   && cmd_op == OP_RD_START;
        acc_stop  = key_ok && state_q == ST_RDMODE && cmd_op == OP_RD_STOP;
        do_prog   = key_ok && state_q == ST_IDLE   && cmd_op == OP_SIG_PROG
                    && (cmd_arg < 16'(NPAGES));
        do_erase  = key_ok && state_q == ST_IDLE   && cmd_op == OP_SIG_ERASE;
        cmd_bad   = cmd_we && !(acc_start || acc_stop || do_prog || do_erase);
    end

    assign page_sel = cmd_arg[PG_W-1:0];
    assign rd_mode  = (state_q == ST_RDMODE);

    // State, busy counter, ready, error flags and interrupt update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            ready     <= 1'b1;
            err_cmd   <= 1'b0;
            err_flash <= 1'b0;
            irq       <= 1'b0;
        end else begin
            if (stat_rd) begin
                err_cmd   <= 1'b0;
                err_flash <= 1'b0;
                irq       <= 1'b0;
            end
            if (cmd_bad) err_cmd <= 1'b1;
            unique case (state_q)
                ST_IDLE: begin
                    if (acc_start) begin
                        state_q <= ST_RDMODE;
                        ready   <= 1'b0;
                    end else if (do_prog || do_erase) begin
                        state_q <= ST_BUSY;
                        ready   <= 1'b0;
                        cnt_q   <= CNT_W'(PROG_CYCLES - 1);
                    end
                end
                ST_RDMODE: begin
                    if (acc_stop) begin
                        state_q <= ST_IDLE;
                        ready   <= 1'b1;
                        if (ien) irq <= 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_IDLE;
                        ready   <= 1'b1;
                        if (vfy_fail) err_flash <= 1'b1;
                        if (ien) irq <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: a wrong keyword always leaves the command-error flag set.
    p_badkey_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_key != CMD_KEY) |=> err_cmd);

    // R2: a wrong keyword in the idle state leaves the state idle.
    p_badkey_noexec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_key != CMD_KEY && state_q == ST_IDLE) |=> (state_q == ST_IDLE && ready));

    // R7: a command while busy is flagged and the busy window continues.
    p_busy_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && state_q == ST_BUSY && cnt_q != '0) |=> (err_cmd && !ready));

    // R3: an accepted start drops ready and enters the read mode.
    p_start_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_start |=> (!ready && rd_mode));

    // R4: an accepted stop raises ready and leaves the read mode.
    p_stop_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stop |=> (ready && !rd_mode));

    // R10: ready rising with the enable set raises the interrupt.
    p_irq_on_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && $past(ien)) |-> irq);
endmodule

// File: rtl/nvm_sig_ctrl.sv
// Top: register interface, mode register, flash read window with the
// signature overlay, and the main-array pattern model. Assumes
// FLASH_WORDS >= SIG_WORDS and at most 65536 words.
module nvm_sig_ctrl
    import nvm_sig_pkg::*;
#(
    parameter int FLASH_WORDS = 1024,
    parameter int SIG_WORDS   = 128,
    parameter int PAGE_WORDS  = 64,
    parameter int PROG_CYCLES = 16,
    parameter int AW          = $clog2(FLASH_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          fl_wr,
    input  logic [AW-1:0] fl_addr,
    input  logic [31:0]   fl_wdata,
    output logic [31:0]   fl_rdata,
    input  logic          array_defect,
    output logic          irq
);
    localparam int DW     = 32;
    localparam int SAW    = $clog2(SIG_WORDS);
    localparam int LW     = $clog2(PAGE_WORDS);
    localparam int NPAGES = SIG_WORDS / PAGE_WORDS;
    localparam int PG_W   = $clog2(NPAGES);

    logic                     ien_q;
    logic                     cmd_we, stat_rd;
    logic                     ready, rd_mode, err_cmd, err_flash;
    logic                     do_prog, do_erase, vfy_fail;
    logic [PG_W-1:0]          page_sel;
    logic [PAGE_WORDS*DW-1:0] latch_flat;
    logic [DW-1:0]            sig_word;

    assign cmd_we  = reg_wr && (reg_addr == REG_CMD);
    assign stat_rd = reg_rd && (reg_addr == REG_STAT);

    // Mode register: interrupt enable in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ien_q <= 1'b0;
        else if (reg_wr && reg_addr == REG_MODE) ien_q <= reg_wdata[0];
    end

    // Register read mux.
    always_comb begin
        unique case (reg_addr)
            REG_MODE: reg_rdata = {31'd0, ien_q};
            REG_STAT: reg_rdata = {29'd0, err_flash, err_cmd, ready};
            default:  reg_rdata = '0;
        endcase
    end

    // Flash read window: the signature overlays the low words in read mode.
    always_comb begin
        if (rd_mode && fl_addr < AW'(SIG_WORDS)) fl_rdata = sig_word;
        else                                   fl_rdata = 32'hC0DE0000 | 32'(fl_addr);
    end

    nvm_cmd_engine #(
        .PROG_CYCLES (PROG_CYCLES),
        .NPAGES      (NPAGES)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .cmd_key   (reg_wdata[31:24]),
        .cmd_arg   (reg_wdata[23:8]),
        .cmd_op    (reg_wdata[7:0]),
        .ien       (ien_q),
        .stat_rd   (stat_rd),
        .vfy_fail  (vfy_fail),
        .ready     (ready),
        .rd_mode   (rd_mode),
        .err_cmd   (err_cmd),
        .err_flash (err_flash),
        .irq       (irq),
        .do_prog   (do_prog),
        .do_erase  (do_erase),
        .page_sel  (page_sel)
    );

    nvm_page_latch #(
        .WORDS (PAGE_WORDS),
        .DW    (DW)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (fl_wr),
        .wr_slot   (fl_addr[LW-1:0]),
        .wr_data   (fl_wdata),
        .page_flat (latch_flat)
    );

    nvm_sig_array #(
        .SIG_WORDS  (SIG_WORDS),
        .PAGE_WORDS (PAGE_WORDS),
        .DW         (DW)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_en    (do_prog),
        .erase_en   (do_erase),
        .page_sel   (page_sel),
        .defect     (array_defect),
        .latch_flat (latch_flat),
        .rd_idx     (fl_addr[SAW-1:0]),
        .rd_word    (sig_word),
        .vfy_fail   (vfy_fail)
    );

    // R9: a status read leaves ready unchanged.
    p_statrd_keeps_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && ready && !cmd_we) |=> ready);
endmodule

// File: tb/nvm_sig_ctrl_tb.sv
// Bench for nvm_sig_ctrl: a table of command vectors, then directed tests.
module nvm_sig_ctrl_tb;
    localparam int P  = 6;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0, reg_rdata;
    logic          fl_wr = 1'b0;
    logic [AW-1:0] fl_addr = '0;
    logic [31:0]   fl_wdata = '0, fl_rdata;
    logic          array_defect = 1'b0;
    logic          irq;

    int n_chk = 0, n_fail = 0;
    logic [31:0] d;

    always #5 clk = ~clk;

    nvm_sig_ctrl #(.PROG_CYCLES(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fl_wr(fl_wr), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata), .array_defect(array_defect), .irq(irq)
    );

    typedef struct packed {
        logic [31:0] cmd;
        logic [2:0]  exp;   // {flash err, cmd err, ready}
        logic [7:0]  rq;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'h5B000021, 3'b011, 8'd2},   // R2 wrong keyword, start not run
        '{32'h5A000021, 3'b000, 8'd3},   // R3 start read mode
        '{32'h5A000021, 3'b010, 8'd11},  // R11 start in read mode
        '{32'h5A000024, 3'b010, 8'd11},  // R11 erase in read mode
        '{32'h5A000022, 3'b001, 8'd4},   // R4 stop
        '{32'h5A000022, 3'b011, 8'd11},  // R11 stop outside read mode
        '{32'h5A000099, 3'b011, 8'd11},  // R11 unknown opcode
        '{32'h5A000024, 3'b001, 8'd6}    // R6 erase
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic flrd(input int a, output logic [31:0] v);
        @(negedge clk);
        fl_addr = AW'(a);
        #1 v = fl_rdata;
    endtask

    task automatic flwr(input int a, input logic [31:0] v);
        @(negedge clk);
        fl_wr = 1'b1; fl_addr = AW'(a); fl_wdata = v;
        @(posedge clk); #1;
        fl_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (P + 2) @(posedge clk);
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'hA5000000 | (i << 8) | i;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int nlow;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(2'd2, d); chk("R1 status after reset", d, 32'h1);
        rd(2'd0, d); chk("R1 mode after reset", d, 32'h0);
        @(negedge clk); chk("R1 irq after reset", {31'd0, irq}, 32'h0);
        flrd(5, d); chk("R1 main pattern", d, 32'hC0DE0005);

        // Table walk: R2 R3 R4 R6 R11
        for (int k = 0; k < 8; k++) begin
            wr(2'd1, VECS[k].cmd);
            settle();
            rd(2'd2, d);
            n_chk++;
            if (d[2:0] !== VECS[k].exp) begin
                n_fail++;
                $display("FAIL R%0d vector %0d actual=%h expected=%h",
                         VECS[k].rq, k, d[2:0], VECS[k].exp);
            end
        end
        @(negedge clk); chk("R10 no irq with enable clear", {31'd0, irq}, 32'h0);

        // R1 signature erased after reset and erase
        wr(2'd1, 32'h5A000021);
        flrd(0, d); chk("R1 signature word 0 erased", d, 32'hFFFFFFFF);
        wr(2'd1, 32'h5A000022);

        // R5 fill latch through page addresses above 127, program page 1
        for (int i = 0; i < 64; i++) flwr(256 + i, pat(i));
        wr(2'd1, 32'h5A000123);
        nlow = 0;
        for (int i = 0; i < 40; i++) begin
            rd(2'd2, d);
            if (d[0]) break;
            nlow++;
        end
        chk("R5 busy window length", nlow, P);
        rd(2'd2, d); chk("R5 status after program", d, 32'h1);
        wr(2'd1, 32'h5A000021);
        flrd(67, d);  chk("R5 page 1 word 3", d, pat(3));
        flrd(127, d); chk("R5 page 1 last word", d, pat(63));
        flrd(0, d);   chk("R5 page 0 untouched", d, 32'hFFFFFFFF);
        flrd(130, d); chk("R3 above overlay", d, 32'hC0DE0082);
        flrd(128, d); chk("R3 first word past overlay", d, 32'hC0DE0080);
        wr(2'd1, 32'h5A000022);
        flrd(67, d);  chk("R4 main restored", d, 32'hC0DE0043);

        // R11 program with arg out of range
        wr(2'd1, 32'h5A000223);
        settle();
        rd(2'd2, d); chk("R11 page arg out of range", d, 32'h3);

        // R7 command during busy is ignored
        wr(2'd1, 32'h5A000024);
        wr(2'd1, 32'h5A000021);
        settle();
        rd(2'd2, d); chk("R7 busy command error", d, 32'h3);
        flrd(0, d);  chk("R7 start not executed", d, 32'hC0DE0000);
        wr(2'd1, 32'h5A000021);
        flrd(64, d); chk("R6 erase reached page 1", d, 32'hFFFFFFFF);
        wr(2'd1, 32'h5A000022);

        // R8 defect: erase and odd-data program fail, even-data program passes
        array_defect = 1'b1;
        wr(2'd1, 32'h5A000024);
        settle();
        rd(2'd2, d); chk("R8 erase verify fail", d, 32'h5);
        rd(2'd2, d); chk("R9 flags cleared ready kept", d, 32'h1);
        wr(2'd1, 32'h5A000023);
        settle();
        rd(2'd2, d); chk("R8 program verify fail", d, 32'h5);
        for (int i = 0; i < 64; i++) flwr(i, pat(i) & 32'hFFFFFFFE);
        wr(2'd1, 32'h5A000023);
        settle();
        rd(2'd2, d); chk("R8 even data passes", d, 32'h1);
        array_defect = 1'b0;

        // R10 interrupt
        wr(2'd0, 32'h1);
        rd(2'd0, d); chk("R10 mode readback", d, 32'h1);
        wr(2'd1, 32'h5A000024);
        settle();
        @(negedge clk); chk("R10 irq after erase", {31'd0, irq}, 32'h1);
        rd(2'd2, d);
        @(negedge clk); chk("R9 irq cleared by status read", {31'd0, irq}, 32'h0);
        wr(2'd1, 32'h5A000021);
        @(negedge clk); chk("R10 no irq on ready fall", {31'd0, irq}, 32'h0);
        wr(2'd1, 32'h5A000022);
        @(negedge clk); chk("R10 irq after stop", {31'd0, irq}, 32'h1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule